// File: doc/BRIEF.md
# NAND Flash Bus-Cycle Sequencer

This block sits on the host side of an asynchronous 8-bit parallel NAND flash bus. An internal client asks for one operation at a time through a valid/acknowledge pair. The block turns that request into bus cycles on the flash pins: a command latch, a command followed by a full address, a bare address, one data byte written or one data byte read. It drives chip enable, the two latch-enable lines, the write and read strobes and write protect. The 8-bit I/O path is split into an output byte, an output enable and an input byte, so the pad cell is left to the chip top.

Every strobe low and high time is a count of system clocks set by a parameter. This keeps each pulse well clear of the flash's glitch filter. For program and erase sequences, the client marks the first request as modifying. Write protect is then released for the whole sequence. The client marks the last request of the sequence as one that must wait for the ready/busy line. The sequencer waits a settle delay, then waits for ready. If ready does not return within a bounded number of clocks, it reports a timeout.

Top module: `nand_bus_seq`

## Requirements
- R1: After reset and whenever no operation is in progress: fl_ce_n, fl_we_n and fl_re_n are 1; fl_cle, fl_ale, fl_io_oe, fl_wp_n and ack are 0.
- R2: A command cycle holds fl_ce_n=0, fl_cle=1, fl_ale=0, fl_re_n=1 and fl_io_oe=1, with the command byte on fl_io_o. fl_we_n is low for WE_LO_CLKS clocks and then high for WE_HI_CLKS clocks. When a command-only request (req_op=0) has no wait, ack follows WE_HI_CLKS clocks after the rising edge of fl_we_n.
- R3: An address phase is exactly ADDR_BYTES (default 4) write strobes with fl_ale=1 and fl_cle=0. The bytes go out least significant first: req_addr[7:0] first, then [15:8], and so on. Successive rising edges of fl_we_n are WE_LO_CLKS+WE_HI_CLKS clocks apart. Operation code req_op=2 issues only the address phase.
- R4: Operation code req_op=1 issues one command cycle immediately followed by the full address phase, in that order, all under a single request.
- R5: A data-input request (req_op=3) issues one write strobe with fl_cle=0, fl_ale=0, fl_ce_n=0, fl_io_oe=1 and req_wdata on fl_io_o.
- R6: A data-output request (req_op=4) issues one fl_re_n low pulse of RE_LO_CLKS clocks, followed by RE_HI_CLKS clocks high. No write strobe is issued. fl_io_oe stays 0 throughout. rdata returns the fl_io_i value present at the rise of fl_re_n, and is valid when ack is high.
- R7: fl_io_o does not change while fl_we_n is low, nor at the clock edge where fl_we_n rises.
- R8: fl_wp_n is 0 unless a request with req_modify=1 has been accepted. From that acceptance it stays 1 through later requests. It returns to 0 only when a request with req_wait_rb=1 completes.
- R9: With req_wait_rb=1, ack is held back until fl_rb is seen high, after a settle delay of WB_CLKS clocks. If fl_rb rises late, ack appears one clock after fl_rb is sampled high.
- R10: If fl_rb stays low for RB_TIMEOUT_CLKS clocks while waiting, the request is acknowledged with rb_timeout=1. The flag is cleared when the next request is accepted.
- R11: ack is a single-clock pulse, issued exactly once per accepted request.
- R12: fl_cle and fl_ale are never high together, fl_we_n and fl_re_n are never low together, and no strobe goes low while fl_ce_n is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Operation request, held until ack |
| req_op | input | 3 | 0 command, 1 command+address, 2 address, 3 data in, 4 data out |
| req_modify | input | 1 | Request opens a program/erase sequence (release write protect) |
| req_wait_rb | input | 1 | Wait for ready after the bus cycles; closes a modify sequence |
| req_cmd | input | 8 | Command byte |
| req_addr | input | 8*ADDR_BYTES | Address, sent least significant byte first |
| req_wdata | input | 8 | Byte to write |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Byte read by a data-output request |
| rb_timeout | output | 1 | Ready wait expired on the last request |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_re_n | output | 1 | Read strobe, active low |
| fl_wp_n | output | 1 | Write protect, active low |
| fl_io_o | output | 8 | Byte driven toward the I/O pads |
| fl_io_oe | output | 1 | Output enable for the I/O pads |
| fl_io_i | input | 8 | Byte received from the I/O pads |
| fl_rb | input | 1 | Ready (1) / busy (0) from the flash |

## Verification
The properties assume a client that keeps req_valid high until ack and lowers it in the clock after ack, so a finished request is never taken twice. The bench drives every request through one task that raises req_valid away from the clock edge and drops it as soon as ack is seen. fl_rb and fl_io_i are assumed stable around the edges where the block samples them. The bench changes them only on falling clock edges and holds the read byte constant for the whole read strobe. The ready line is lowered only before a waiting request, and the bench raises it long after the settle delay has ended.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

   localparam int BYTE_W = 8;

   // request operation codes (values are part of the port contract)
   localparam logic [2:0] OP_CMD      = 3'd0;
   localparam logic [2:0] OP_CMD_ADDR = 3'd1;
   localparam logic [2:0] OP_ADDR     = 3'd2;
   localparam logic [2:0] OP_DIN      = 3'd3;
   localparam logic [2:0] OP_DOUT     = 3'd4;

   typedef enum logic [2:0] {
      S_IDLE,
      S_CMD,
      S_ADDR,
      S_DIN,
      S_DOUT,
      S_SETTLE,
      S_RBWAIT,
      S_DONE
   } seq_state_e;

endpackage

// File: rtl/nbs_strobe_gen.sv
// Produces one low/high strobe period, either on the write or on the read line.
module nbs_strobe_gen #(
   parameter int W_LO = 2,
   parameter int W_HI = 2,
   parameter int R_LO = 2,
   parameter int R_HI = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic rd,
   output logic done,
   output logic sample,
   output logic we_n,
   output logic re_n
);

   localparam int MAX_WR = (W_LO > W_HI) ? W_LO : W_HI;
   localparam int MAX_RD = (R_LO > R_HI) ? R_LO : R_HI;
   localparam int MAX_C  = (MAX_WR > MAX_RD) ? MAX_WR : MAX_RD;
   localparam int CW     = (MAX_C > 1) ? $clog2(MAX_C) : 1;

   if (W_LO < 1 || W_HI < 1 || R_LO < 1 || R_HI < 1) begin : g_bad_width
      $error("strobe phase widths must be at least one clock");
   end

   logic          busy_q;
   logic          lo_q;
   logic          rd_q;
   logic [CW-1:0] cnt_q;
   logic          cnt_zero;

   assign cnt_zero = (cnt_q == '0);
   assign done     = busy_q && !lo_q && cnt_zero;
   assign sample   = busy_q && lo_q && rd_q && cnt_zero;
   assign we_n     = !(busy_q && lo_q && !rd_q);
   assign re_n     = !(busy_q && lo_q && rd_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         lo_q   <= 1'b0;
         rd_q   <= 1'b0;
         cnt_q  <= '0;
      end else if (start && (!busy_q || done)) begin
         busy_q <= 1'b1;
         lo_q   <= 1'b1;
         rd_q   <= rd;
         cnt_q  <= rd ? CW'(R_LO - 1) : CW'(W_LO - 1);
      end else if (busy_q) begin
         if (!cnt_zero) begin
            cnt_q <= cnt_q - CW'(1);
         end else if (lo_q) begin
            lo_q  <= 1'b0;
            cnt_q <= rd_q ? CW'(R_HI - 1) : CW'(W_HI - 1);
         end else begin
            busy_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/nbs_rb_wait.sv
// Watches the ready line while the sequencer waits; flags expiry after a limit.
module nbs_rb_wait #(
   parameter int LIMIT = 1000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic rb,
   output logic ready,
   output logic expired
);

   localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

   if (LIMIT < 1) begin : g_bad_limit
      $error("ready timeout must be at least one clock");
   end

   logic [CW-1:0] cnt_q;

   assign ready   = active && rb;
   assign expired = active && !rb && (cnt_q == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!active || rb) begin
         cnt_q <= '0;
      end else if (!expired) begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
   import nbs_pkg::*;
#(
   parameter int WE_LO_CLKS      = 2,
   parameter int WE_HI_CLKS      = 2,
   parameter int RE_LO_CLKS      = 2,
   parameter int RE_HI_CLKS      = 2,
   parameter int WB_CLKS         = 5,
   parameter int RB_TIMEOUT_CLKS = 1000000,
   parameter int ADDR_BYTES      = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   input  logic [2:0]                   req_op,
   input  logic                         req_modify,
   input  logic                         req_wait_rb,
   input  logic [BYTE_W-1:0]            req_cmd,
   input  logic [ADDR_BYTES*BYTE_W-1:0] req_addr,
   input  logic [BYTE_W-1:0]            req_wdata,
   output logic                         ack,
   output logic [BYTE_W-1:0]            rdata,
   output logic                         rb_timeout,
   output logic                         fl_ce_n,
   output logic                         fl_cle,
   output logic                         fl_ale,
   output logic                         fl_we_n,
   output logic                         fl_re_n,
   output logic                         fl_wp_n,
   output logic [BYTE_W-1:0]            fl_io_o,
   output logic                         fl_io_oe,
   input  logic [BYTE_W-1:0]            fl_io_i,
   input  logic                         fl_rb
);

   localparam int AW    = ADDR_BYTES * BYTE_W;
   localparam int IW    = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
   localparam int WBW   = (WB_CLKS > 1) ? $clog2(WB_CLKS) : 1;
   localparam logic [IW-1:0] LAST_IDX = IW'(ADDR_BYTES - 1);

   if (ADDR_BYTES < 1 || ADDR_BYTES > 8) begin : g_bad_addr
      $error("ADDR_BYTES must lie between 1 and 8");
   end
   if (WB_CLKS < 1) begin : g_bad_wb
      $error("WB_CLKS must be at least one clock");
   end

   seq_state_e       st_q, st_d;
   logic [2:0]       op_q;
   logic             wait_q;
   logic [AW-1:0]    addr_q;
   logic [IW-1:0]    idx_q, idx_d, idx_nx;
   logic [BYTE_W-1:0] io_q, io_d;
   logic [BYTE_W-1:0] rdata_q;
   logic [WBW-1:0]   wb_cnt_q;
   logic             to_q;
   logic             wp_q;
   logic             accept;
   logic             finish;
   logic             pg_start, pg_rd, pg_done, pg_sample;
   logic             rb_ok, rb_exp;

   // address bytes, least significant first
   logic [BYTE_W-1:0] addr_b [ADDR_BYTES];
   for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr_byte
      assign addr_b[g] = addr_q[g*BYTE_W +: BYTE_W];
   end

   assign accept = (st_q == S_IDLE) && req_valid;
   assign idx_nx = idx_q + IW'(1);

   always_comb begin
      st_d     = st_q;
      idx_d    = idx_q;
      io_d     = io_q;
      pg_start = 1'b0;
      pg_rd    = 1'b0;
      finish   = 1'b0;
      case (st_q)
         S_IDLE: begin
            if (req_valid) begin
               case (req_op)
                  OP_CMD, OP_CMD_ADDR: begin
                     st_d     = S_CMD;
                     io_d     = req_cmd;
                     pg_start = 1'b1;
                  end
                  OP_ADDR: begin
                     st_d     = S_ADDR;
                     idx_d    = '0;
                     io_d     = req_addr[BYTE_W-1:0];
                     pg_start = 1'b1;
                  end
                  OP_DIN: begin
                     st_d     = S_DIN;
                     io_d     = req_wdata;
                     pg_start = 1'b1;
                  end
                  OP_DOUT: begin
                     st_d     = S_DOUT;
                     pg_start = 1'b1;
                     pg_rd    = 1'b1;
                  end
                  default: st_d = S_DONE;
               endcase
            end
         end
         S_CMD: begin
            if (pg_done) begin
               if (op_q == OP_CMD_ADDR) begin
                  st_d     = S_ADDR;
                  idx_d    = '0;
                  io_d     = addr_b[0];
                  pg_start = 1'b1;
               end else begin
                  finish = 1'b1;
               end
            end
         end
         S_ADDR: begin
            if (pg_done) begin
               if (idx_q == LAST_IDX) begin
                  finish = 1'b1;
               end else begin
                  idx_d    = idx_nx;
                  io_d     = addr_b[idx_nx];
                  pg_start = 1'b1;
               end
            end
         end
         S_DIN, S_DOUT: begin
            if (pg_done) finish = 1'b1;
         end
         S_SETTLE: begin
            if (wb_cnt_q == '0) st_d = S_RBWAIT;
         end
         S_RBWAIT: begin
            if (rb_ok || rb_exp) st_d = S_DONE;
         end
         S_DONE:  st_d = S_IDLE;
         default: st_d = S_IDLE;
      endcase
      if (finish) st_d = wait_q ? S_SETTLE : S_DONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         idx_q  <= '0;
         io_q   <= '0;
         op_q   <= OP_CMD;
         wait_q <= 1'b0;
         addr_q <= '0;
      end else begin
         st_q  <= st_d;
         idx_q <= idx_d;
         io_q  <= io_d;
         if (accept) begin
            op_q   <= req_op;
            wait_q <= req_wait_rb;
            addr_q <= req_addr;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_cnt_q <= '0;
      end else if (finish && wait_q) begin
         wb_cnt_q <= WBW'(WB_CLKS - 1);
      end else if (st_q == S_SETTLE && wb_cnt_q != '0) begin
         wb_cnt_q <= wb_cnt_q - WBW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         to_q    <= 1'b0;
         wp_q    <= 1'b0;
      end else begin
         if (pg_sample) rdata_q <= fl_io_i;
         if (accept) begin
            to_q <= 1'b0;
         end else if (st_q == S_RBWAIT && rb_exp) begin
            to_q <= 1'b1;
         end
         if (accept && req_modify) begin
            wp_q <= 1'b1;
         end else if (st_q == S_DONE && wait_q) begin
            wp_q <= 1'b0;
         end
      end
   end

   nbs_strobe_gen #(
      .W_LO (WE_LO_CLKS),
      .W_HI (WE_HI_CLKS),
      .R_LO (RE_LO_CLKS),
      .R_HI (RE_HI_CLKS)
   ) u_strobe (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (pg_start),
      .rd     (pg_rd),
      .done   (pg_done),
      .sample (pg_sample),
      .we_n   (fl_we_n),
      .re_n   (fl_re_n)
   );

   nbs_rb_wait #(
      .LIMIT (RB_TIMEOUT_CLKS)
   ) u_rbw (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (st_q == S_RBWAIT),
      .rb      (fl_rb),
      .ready   (rb_ok),
      .expired (rb_exp)
   );

   assign ack        = (st_q == S_DONE);
   assign rdata      = rdata_q;
   assign rb_timeout = to_q;
   assign fl_ce_n    = (st_q == S_IDLE);
   assign fl_cle     = (st_q == S_CMD);
   assign fl_ale     = (st_q == S_ADDR);
   assign fl_wp_n    = wp_q;
   assign fl_io_o    = io_q;
   assign fl_io_oe   = (st_q == S_CMD) || (st_q == S_ADDR) || (st_q == S_DIN);

endmodule

// File: rtl/nbs_checker.sv
module nbs_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       ack,
   input logic       fl_ce_n,
   input logic       fl_cle,
   input logic       fl_ale,
   input logic       fl_we_n,
   input logic       fl_re_n,
   input logic       fl_wp_n,
   input logic [7:0] fl_io_o,
   input logic       fl_io_oe
);

   p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fl_ce_n |-> (fl_we_n && fl_re_n && !fl_cle && !fl_ale && !fl_io_oe));

   p_cmd_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fl_cle |-> (fl_io_oe && fl_re_n && !fl_ce_n));

   p_read_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_re_n |-> !fl_io_oe);

   p_io_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_we_n |=> $stable(fl_io_o));

   p_wp_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fl_wp_n) |-> $past(ack));

   p_ack_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);

   p_latch_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_cle && fl_ale));

   p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(!fl_we_n && !fl_re_n));

   p_strobe_ce_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl_we_n || !fl_re_n) |-> !fl_ce_n);

endmodule

bind nand_bus_seq nbs_checker u_nbs_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .ack      (ack),
   .fl_ce_n  (fl_ce_n),
   .fl_cle   (fl_cle),
   .fl_ale   (fl_ale),
   .fl_we_n  (fl_we_n),
   .fl_re_n  (fl_re_n),
   .fl_wp_n  (fl_wp_n),
   .fl_io_o  (fl_io_o),
   .fl_io_oe (fl_io_oe)
);

// File: tb/tb_nand_bus_seq.sv
`timescale 1ns/1ps
module tb_nand_bus_seq;

   localparam int WLO = 3;
   localparam int WHI = 2;
   localparam int RLO = 4;
   localparam int RHI = 2;
   localparam int WB  = 3;
   localparam int TO  = 200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_op = 3'd0;
   logic        req_modify = 1'b0;
   logic        req_wait_rb = 1'b0;
   logic [7:0]  req_cmd = 8'h00;
   logic [31:0] req_addr = 32'h0;
   logic [7:0]  req_wdata = 8'h00;
   logic        ack;
   logic [7:0]  rdata;
   logic        rb_timeout;
   logic        fl_ce_n, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_wp_n, fl_io_oe;
   logic [7:0]  fl_io_o;
   logic [7:0]  fl_io_i = 8'h00;
   logic        fl_rb = 1'b1;

   always #10 clk = ~clk;

   nand_bus_seq #(
      .WE_LO_CLKS(WLO), .WE_HI_CLKS(WHI), .RE_LO_CLKS(RLO), .RE_HI_CLKS(RHI),
      .WB_CLKS(WB), .RB_TIMEOUT_CLKS(TO), .ADDR_BYTES(4)
   ) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_modify(req_modify), .req_wait_rb(req_wait_rb), .req_cmd(req_cmd),
      .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
      .rb_timeout(rb_timeout), .fl_ce_n(fl_ce_n), .fl_cle(fl_cle), .fl_ale(fl_ale),
      .fl_we_n(fl_we_n), .fl_re_n(fl_re_n), .fl_wp_n(fl_wp_n), .fl_io_o(fl_io_o),
      .fl_io_oe(fl_io_oe), .fl_io_i(fl_io_i), .fl_rb(fl_rb)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // write-strobe log
   int         n_rec = 0;
   logic [7:0] rec_byte [64];
   logic       rec_cle  [64];
   logic       rec_ale  [64];
   logic       rec_oe   [64];
   logic       rec_wp   [64];
   logic       rec_iobad[64];
   int         rec_lo   [64];
   int         rec_rise [64];
   // read-strobe log
   int n_re = 0;
   int re_lo_last = 0;
   int re_rise_last = 0;
   // bus-level counters
   int ack_cnt = 0;
   int ack_dbl = 0;
   int bad_r12 = 0;
   int bad_oe_rd = 0;

   logic       prev_we = 1'b1, prev_re = 1'b1, prev_ack = 1'b0;
   int         we_lo = 0, re_lo = 0;
   logic [7:0] first_io = 8'h00;
   logic       io_bad = 1'b0;
   logic       c_cle, c_ale, c_oe, c_wp;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!fl_we_n) begin
            if (prev_we) begin
               we_lo = 0; first_io = fl_io_o; io_bad = 1'b0;
            end
            we_lo++;
            if (fl_io_o != first_io) io_bad = 1'b1;
            c_cle = fl_cle; c_ale = fl_ale; c_oe = fl_io_oe; c_wp = fl_wp_n;
         end else if (!prev_we) begin
            if (fl_io_o != first_io) io_bad = 1'b1;
            if (n_rec < 64) begin
               rec_byte[n_rec] = first_io; rec_cle[n_rec] = c_cle; rec_ale[n_rec] = c_ale;
               rec_oe[n_rec] = c_oe; rec_wp[n_rec] = c_wp; rec_iobad[n_rec] = io_bad;
               rec_lo[n_rec] = we_lo; rec_rise[n_rec] = cyc;
               n_rec++;
            end
         end
         if (!fl_re_n) begin
            if (prev_re) re_lo = 0;
            re_lo++;
         end else if (!prev_re) begin
            re_lo_last = re_lo; re_rise_last = cyc; n_re++;
         end
         if (ack) ack_cnt++;
         if (ack && prev_ack) ack_dbl++;
         if (fl_cle && fl_ale) bad_r12++;
         if (!fl_we_n && !fl_re_n) bad_r12++;
         if ((!fl_we_n || !fl_re_n) && fl_ce_n) bad_r12++;
         if (!fl_re_n && fl_io_oe) bad_oe_rd++;
      end
      prev_we = fl_we_n; prev_re = fl_re_n; prev_ack = ack;
   end

   task automatic chk(input logic ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   int         ack_cyc;
   int         start_cyc;
   logic [7:0] got_rdata;
   logic       got_to;
   int         n_req = 0;

   task automatic do_req(input logic [2:0] op, input logic md, input logic wt,
                         input logic [7:0] c, input logic [31:0] a, input logic [7:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_modify = md; req_wait_rb = wt;
      req_cmd = c; req_addr = a; req_wdata = d;
      start_cyc = cyc;
      n_req++;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (ack) break;
      end
      ack_cyc = cyc; got_rdata = rdata; got_to = rb_timeout;
      req_valid = 1'b0;
   endtask

   task automatic t_reset;
      chk(fl_ce_n && fl_we_n && fl_re_n, "R1 strobes idle high", {fl_ce_n, fl_we_n, fl_re_n}, 3'b111);
      chk(!fl_cle && !fl_ale && !fl_io_oe && !fl_wp_n && !ack, "R1 latches/oe/wp/ack low",
          {fl_cle, fl_ale, fl_io_oe, fl_wp_n, ack}, 5'b0);
   endtask

   task automatic t_cmd;
      int b = n_rec;
      do_req(3'd0, 1'b0, 1'b0, 8'h70, 32'h0, 8'h00);
      chk(n_rec == b + 1, "R2 one write strobe", n_rec - b, 1);
      chk(rec_byte[b] == 8'h70, "R2 command byte", rec_byte[b], 8'h70);
      chk(rec_cle[b] && !rec_ale[b] && rec_oe[b], "R2 latch lines", {rec_cle[b], rec_ale[b], rec_oe[b]}, 3'b101);
      chk(rec_lo[b] == WLO, "R2 we low width", rec_lo[b], WLO);
      chk(ack_cyc == rec_rise[b] + WHI, "R2 we high width before ack", ack_cyc - rec_rise[b], WHI);
      chk(!rec_iobad[b], "R7 io held over strobe", rec_iobad[b], 0);
      chk(!rec_wp[b], "R8 wp low without modify", rec_wp[b], 0);
      @(negedge clk);
      chk(fl_ce_n && !fl_io_oe, "R1 idle after op", {fl_ce_n, fl_io_oe}, 2'b10);
   endtask

   task automatic t_cmd_addr;
      int b = n_rec;
      logic [31:0] a = 32'hA1B2C3D4;
      do_req(3'd1, 1'b0, 1'b0, 8'h00, a, 8'h00);
      chk(n_rec == b + 5, "R4 command plus four address strobes", n_rec - b, 5);
      chk(rec_cle[b] && rec_byte[b] == 8'h00, "R4 command first", rec_byte[b], 8'h00);
      for (int k = 0; k < 4; k++) begin
         chk(rec_ale[b+1+k] && !rec_cle[b+1+k], "R3 ale-only address cycle",
             {rec_cle[b+1+k], rec_ale[b+1+k]}, 2'b01);
         chk(rec_byte[b+1+k] == a[8*k +: 8], "R3 address byte order", rec_byte[b+1+k], a[8*k +: 8]);
         chk(rec_rise[b+1+k] - rec_rise[b+k] == WLO + WHI, "R3 strobe period",
             rec_rise[b+1+k] - rec_rise[b+k], WLO + WHI);
         chk(!rec_iobad[b+1+k], "R7 address byte held", rec_iobad[b+1+k], 0);
      end
   endtask

   task automatic t_addr_only;
      int b = n_rec;
      do_req(3'd2, 1'b0, 1'b0, 8'hFF, 32'h01020304, 8'h00);
      chk(n_rec == b + 4, "R3 address-only strobe count", n_rec - b, 4);
      chk(rec_ale[b] && rec_byte[b] == 8'h04 && rec_byte[b+3] == 8'h01, "R3 address-only order",
          {rec_byte[b], rec_byte[b+3]}, 16'h0401);
   endtask

   task automatic t_din(input logic [7:0] d);
      int b = n_rec;
      do_req(3'd3, 1'b0, 1'b0, 8'h00, 32'h0, d);
      chk(n_rec == b + 1 && rec_byte[b] == d, "R5 data byte", rec_byte[b], d);
      chk(!rec_cle[b] && !rec_ale[b] && rec_oe[b], "R5 data latch lines",
          {rec_cle[b], rec_ale[b], rec_oe[b]}, 3'b001);
   endtask

   task automatic t_dout(input logic [7:0] v);
      int b = n_rec;
      int r = n_re;
      fl_io_i = v;
      do_req(3'd4, 1'b0, 1'b0, 8'h00, 32'h0, 8'h00);
      chk(n_rec == b && n_re == r + 1, "R6 one read strobe, no write", n_re - r, 1);
      chk(re_lo_last == RLO, "R6 re low width", re_lo_last, RLO);
      chk(ack_cyc == re_rise_last + RHI, "R6 re high width before ack", ack_cyc - re_rise_last, RHI);
      chk(got_rdata == v, "R6 read byte", got_rdata, v);
      chk(bad_oe_rd == 0, "R6 bus released during read", bad_oe_rd, 0);
      fl_io_i = 8'h00;
   endtask

   task automatic t_program;
      int b = n_rec;
      int raise_cyc = 0;
      do_req(3'd1, 1'b1, 1'b0, 8'h80, 32'h00000010, 8'h00);
      chk(rec_wp[b] && rec_wp[b+4], "R8 wp high through modify cmd/addr", {rec_wp[b], rec_wp[b+4]}, 2'b11);
      chk(fl_wp_n, "R8 wp held after first request", fl_wp_n, 1);
      t_din(8'h5A);
      chk(rec_wp[n_rec-1], "R8 wp high during data", rec_wp[n_rec-1], 1);
      fl_rb = 1'b0;
      fork
         do_req(3'd0, 1'b0, 1'b1, 8'h10, 32'h0, 8'h00);
         begin
            repeat (30) @(negedge clk);
            fl_rb = 1'b1;
            raise_cyc = cyc;
         end
      join
      chk(ack_cyc == raise_cyc + 1, "R9 ack one clock after ready", ack_cyc - raise_cyc, 1);
      chk(!got_to, "R10 no timeout on ready", got_to, 0);
      chk(rec_wp[n_rec-1], "R8 wp high on confirm command", rec_wp[n_rec-1], 1);
      @(negedge clk);
      chk(!fl_wp_n, "R8 wp released after wait completes", fl_wp_n, 0);
      t_din(8'hA5);
      chk(!rec_wp[n_rec-1], "R8 wp low for later plain data", rec_wp[n_rec-1], 0);
   endtask

   task automatic t_timeout;
      fl_rb = 1'b0;
      do_req(3'd0, 1'b1, 1'b1, 8'hD0, 32'h0, 8'h00);
      chk(got_to, "R10 timeout flag", got_to, 1);
      chk(ack_cyc - start_cyc >= TO, "R10 waited full limit", ack_cyc - start_cyc, TO);
      fl_rb = 1'b1;
      do_req(3'd0, 1'b0, 1'b0, 8'h70, 32'h0, 8'h00);
      chk(!got_to, "R10 flag cleared by next request", got_to, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset;
      t_cmd;
      t_cmd_addr;
      t_addr_only;
      t_din(8'h5A);
      t_din(8'hA5);
      t_dout(8'h3C);
      t_dout(8'hC3);
      t_program;
      t_timeout;
      repeat (4) @(negedge clk);
      chk(ack_cnt == n_req, "R11 one ack per request", ack_cnt, n_req);
      chk(ack_dbl == 0, "R11 ack single cycle", ack_dbl, 0);
      chk(bad_r12 == 0, "R12 exclusive lines", bad_r12, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule